// File: doc/BRIEF.md
# Stack and Control-Flow Unit

This unit owns the stack pointer and every change of program counter that does not come from plain sequential fetch in a small 8-bit processor. The processor has a single 256-byte address space, which code, data and the stack share. An instruction decoder hands the unit one request at a time. The request carries the opcode byte, the address of the current instruction, the immediate byte, the contents of the named general register and the zero flag. The unit then reports the address of the next instruction. When the request is a pop, it also returns the byte read for the register file.

Stack traffic goes through a plain memory port that completes in one cycle. The stack grows downward from the top of memory. A push writes at the stack pointer and then moves it down. A pop moves it up and then reads. Calls save a one-byte return address, which is the address of the byte just after the call. The call target comes either from the immediate or from a register. Stack-pointer and program-counter arithmetic both wrap modulo 256, and nothing traps.

Top module: `stack_flow_unit`

## Requirements
- R1: While reset is active and after it is released, the stack pointer reads 0xFF, and `busy`, `pc_valid`, `pop_valid`, `mem_we` and `mem_re` are all 0.
- R2: Only these opcode values are acted on: 0x07 push, 0x08 pop, 0x16 jump, 0x17 jump-if-zero, 0x18 jump-if-not-zero, 0x20 call, 0x21 return, 0x25 jump-to-register, 0x26 call-via-register. Any other opcode gives no `pc_valid`, no busy cycle and no memory strobe, and leaves the stack pointer unchanged.
- R3: An accepted 0x16 sets `pc_valid` in the next cycle, with `pc_next` equal to `imm_addr`. An accepted 0x25 does the same with `pc_next` equal to `reg_val`. Neither touches memory.
- R4: 0x17 yields `imm_addr` when `zero_flag` is 1, and 0x18 yields it when `zero_flag` is 0. When the condition fails, `pc_next` is `cur_pc` + 2. The result is reported in the cycle after acceptance.
- R5: A push (0x07) takes one busy cycle, starting the cycle after acceptance. In that cycle `mem_we` is 1, `mem_addr` equals the stack pointer and `mem_wdata` equals `reg_val`. In the following cycle the stack pointer is one lower and `pc_next` is `cur_pc` + 2.
- R6: A pop (0x08) takes one busy cycle. In that cycle `mem_re` is 1 and `mem_addr` is the stack pointer + 1. In the following cycle the stack pointer is one higher, `pop_valid` and `pc_valid` are 1, `pop_data` holds the byte read, and `pc_next` is `cur_pc` + 2.
- R7: A call (0x20 with the target from `imm_addr`, 0x26 with the target from `reg_val`) writes `cur_pc` + 2 at the stack pointer during its busy cycle. The stack pointer then drops by one and `pc_next` is the target.
- R8: A return (0x21) reads at the stack pointer + 1 during its busy cycle. The stack pointer then rises by one and `pc_next` equals the byte read.
- R9: Each stack access holds `busy` for exactly one cycle. A request presented while `busy` is 1 is dropped and leaves no later effect.
- R10: The stack pointer wraps from 0x00 to 0xFF on a push and from 0xFF to 0x00 on a pop. `cur_pc` + 2 wraps modulo 256.
- R11: `mem_we` and `mem_re` are never both 1, and either one is 1 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A decoded request is present |
| req_op | input | 8 | Opcode byte of the request |
| cur_pc | input | 8 | Address of the current instruction |
| imm_addr | input | 8 | Immediate target address |
| reg_val | input | 8 | Contents of the named general register |
| zero_flag | input | 1 | Zero flag from the ALU |
| busy | output | 1 | A stack access is in progress; requests are not taken |
| pc_valid | output | 1 | `pc_next` is valid this cycle |
| pc_next | output | 8 | Address of the next instruction |
| pop_valid | output | 1 | `pop_data` should be written to the register file |
| pop_data | output | 8 | Byte popped from the stack |
| sp_value | output | 8 | Current stack pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory address for stack traffic |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of `mem_re` |

## Verification
The hardest situations to reach are the stack pointer crossing the 0x00/0xFF boundary and a request arriving during a busy cycle. The vector table first balances pushes, calls, returns and pops to return the pointer to 0xFF. It then pops once more, so the pointer reaches 0x00 and reads the byte at address 0. A push at that point wraps it back, and that push's instruction at 0xFE also wraps `cur_pc` + 2. The drop case is reached by holding `req_valid` high with a jump through the busy cycle of a push. The bench then checks that only the push result ever appears.

// File: rtl/stack_flow_pkg.sv
package stack_flow_pkg;

  localparam int unsigned OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_PUSH  = 8'h07;
  localparam logic [OPC_W-1:0] OPC_POP   = 8'h08;
  localparam logic [OPC_W-1:0] OPC_JMP   = 8'h16;
  localparam logic [OPC_W-1:0] OPC_JZ    = 8'h17;
  localparam logic [OPC_W-1:0] OPC_JNZ   = 8'h18;
  localparam logic [OPC_W-1:0] OPC_CALL  = 8'h20;
  localparam logic [OPC_W-1:0] OPC_RET   = 8'h21;
  localparam logic [OPC_W-1:0] OPC_JMPR  = 8'h25;
  localparam logic [OPC_W-1:0] OPC_CALLR = 8'h26;

  typedef enum logic [2:0] {
    K_NONE, K_JUMP, K_PUSH, K_POP, K_CALL, K_RET
  } flow_kind_e;

  typedef enum logic [1:0] {
    C_ALWAYS, C_ZSET, C_ZCLR
  } flow_cond_e;

  typedef struct packed {
    flow_kind_e kind;
    flow_cond_e cond;
    logic       use_reg;
    logic [1:0] len;
  } op_class_t;

  typedef enum logic {
    ST_IDLE, ST_ACCESS
  } unit_state_e;

endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
  import stack_flow_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  output op_class_t        cls_o
);

  always_comb begin
    cls_o.kind    = K_NONE;
    cls_o.cond    = C_ALWAYS;
    cls_o.use_reg = 1'b0;
    cls_o.len     = 2'd2;
    unique case (op_i)
      OPC_PUSH:  cls_o.kind = K_PUSH;
      OPC_POP:   cls_o.kind = K_POP;
      OPC_JMP:   cls_o.kind = K_JUMP;
      OPC_JZ: begin
        cls_o.kind = K_JUMP;
        cls_o.cond = C_ZSET;
      end
      OPC_JNZ: begin
        cls_o.kind = K_JUMP;
        cls_o.cond = C_ZCLR;
      end
      OPC_JMPR: begin
        cls_o.kind    = K_JUMP;
        cls_o.use_reg = 1'b1;
      end
      OPC_CALL:  cls_o.kind = K_CALL;
      OPC_CALLR: begin
        cls_o.kind    = K_CALL;
        cls_o.use_reg = 1'b1;
      end
      OPC_RET: begin
        cls_o.kind = K_RET;
        cls_o.len  = 2'd1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sfu_target.sv
module sfu_target
  import stack_flow_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  flow_cond_e   cond_i,
  input  logic         use_reg_i,
  input  logic [1:0]   len_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] reg_i,
  input  logic         zero_i,
  output logic [W-1:0] flow_pc_o,
  output logic [W-1:0] link_pc_o
);

  logic         taken;
  logic [W-1:0] dest;

  always_comb begin
    unique case (cond_i)
      C_ZSET:  taken = zero_i;
      C_ZCLR:  taken = ~zero_i;
      default: taken = 1'b1;
    endcase
    dest      = use_reg_i ? reg_i : imm_i;
    link_pc_o = pc_i + W'(len_i);
    flow_pc_o = taken ? dest : link_pc_o;
  end

endmodule

// File: rtl/sfu_sp.sv
module sfu_sp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         dec_i,
  input  logic         inc_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] sp_up_o
);

  localparam logic [W-1:0] SP_TOP = {W{1'b1}};

  logic [W-1:0] sp_q, sp_d;
  logic         sp_en;

  always_comb begin
    sp_en = dec_i | inc_i;
    sp_d  = dec_i ? (sp_q - 1'b1) : (sp_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_TOP;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_o    = sp_q;
  assign sp_up_o = sp_q + 1'b1;

  // R9: the controller never asks for both directions in one access
  assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !(dec_i && inc_i));

endmodule

// File: rtl/stack_flow_unit.sv
module stack_flow_unit
  import stack_flow_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OPC_W-1:0] req_op,
  input  logic [W-1:0]     cur_pc,
  input  logic [W-1:0]     imm_addr,
  input  logic [W-1:0]     reg_val,
  input  logic             zero_flag,
  output logic             busy,
  output logic             pc_valid,
  output logic [W-1:0]     pc_next,
  output logic             pop_valid,
  output logic [W-1:0]     pop_data,
  output logic [W-1:0]     sp_value,
  output logic             mem_we,
  output logic             mem_re,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  op_class_t    cls;
  logic [W-1:0] flow_pc, link_pc;
  logic [W-1:0] sp_q, sp_up;
  logic         sp_dec, sp_inc;

  sfu_decode u_dec (
    .op_i  (req_op),
    .cls_o (cls)
  );

  sfu_target #(.W(W)) u_tgt (
    .cond_i    (cls.cond),
    .use_reg_i (cls.use_reg),
    .len_i     (cls.len),
    .pc_i      (cur_pc),
    .imm_i     (imm_addr),
    .reg_i     (reg_val),
    .zero_i    (zero_flag),
    .flow_pc_o (flow_pc),
    .link_pc_o (link_pc)
  );

  sfu_sp #(.W(W)) u_sp (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .dec_i   (sp_dec),
    .inc_i   (sp_inc),
    .sp_o    (sp_q),
    .sp_up_o (sp_up)
  );

  unit_state_e  state_q, state_d;
  flow_kind_e   acc_kind_q, acc_kind_d;
  logic [W-1:0] acc_addr_q, acc_addr_d;
  logic [W-1:0] acc_wdata_q, acc_wdata_d;
  logic [W-1:0] acc_pc_q, acc_pc_d;
  logic         acc_load, acc_write, accept;
  logic         pcv_q, pcv_d, pcn_load, popv_q, popv_d, popd_load;
  logic [W-1:0] pcn_q, pcn_d, popd_q;

  always_comb begin
    accept      = req_valid && (state_q == ST_IDLE);
    acc_write   = (acc_kind_q == K_PUSH) || (acc_kind_q == K_CALL);
    state_d     = state_q;
    acc_load    = 1'b0;
    acc_kind_d  = cls.kind;
    acc_addr_d  = sp_q;
    acc_wdata_d = reg_val;
    acc_pc_d    = link_pc;
    pcv_d       = 1'b0;
    pcn_load    = 1'b0;
    pcn_d       = flow_pc;
    popv_d      = 1'b0;
    popd_load   = 1'b0;
    sp_dec      = 1'b0;
    sp_inc      = 1'b0;
    if (state_q == ST_ACCESS) begin
      state_d   = ST_IDLE;
      pcv_d     = 1'b1;
      pcn_load  = 1'b1;
      pcn_d     = (acc_kind_q == K_RET) ? mem_rdata : acc_pc_q;
      popv_d    = (acc_kind_q == K_POP);
      popd_load = (acc_kind_q == K_POP);
      sp_dec    = acc_write;
      sp_inc    = ~acc_write;
    end else if (accept) begin
      unique case (cls.kind)
        K_JUMP: begin
          pcv_d    = 1'b1;
          pcn_load = 1'b1;
        end
        K_PUSH: begin
          state_d  = ST_ACCESS;
          acc_load = 1'b1;
        end
        K_CALL: begin
          state_d     = ST_ACCESS;
          acc_load    = 1'b1;
          acc_wdata_d = link_pc;
          acc_pc_d    = flow_pc;
        end
        K_POP, K_RET: begin
          state_d    = ST_ACCESS;
          acc_load   = 1'b1;
          acc_addr_d = sp_up;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcv_q   <= 1'b0;
      popv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pcv_q   <= pcv_d;
      popv_q  <= popv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_kind_q  <= K_NONE;
      acc_addr_q  <= '0;
      acc_wdata_q <= '0;
      acc_pc_q    <= '0;
    end else if (acc_load) begin
      acc_kind_q  <= acc_kind_d;
      acc_addr_q  <= acc_addr_d;
      acc_wdata_q <= acc_wdata_d;
      acc_pc_q    <= acc_pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       pcn_q <= '0;
    else if (pcn_load) pcn_q <= pcn_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        popd_q <= '0;
    else if (popd_load) popd_q <= mem_rdata;
  end

  assign busy      = (state_q == ST_ACCESS);
  assign mem_we    = busy & acc_write;
  assign mem_re    = busy & ~acc_write;
  assign mem_addr  = acc_addr_q;
  assign mem_wdata = acc_wdata_q;
  assign pc_valid  = pcv_q;
  assign pc_next   = pcn_q;
  assign pop_valid = popv_q;
  assign pop_data  = popd_q;
  assign sp_value  = sp_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_we && mem_re));

  assert_strobe_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we || mem_re) |-> busy);

  assert_busy_single_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> !busy);

  assert_push_addr_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (mem_addr == sp_value));

  assert_push_sp_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |=> (sp_value == $past(sp_value) - 8'd1));

  assert_pop_addr_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_re |-> (mem_addr == sp_value + 8'd1));

  assert_pop_sp_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_re |=> (sp_value == $past(sp_value) + 8'd1));

  assert_pop_has_pc_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_valid |-> pc_valid);

  assert_result_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_valid |-> !busy);

endmodule

// File: tb/stack_flow_unit_tb_top.sv
`timescale 1ns/1ps
module stack_flow_unit_tb_top;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] pc;
    logic [7:0] imm;
    logic [7:0] rv;
    logic       z;
    logic [7:0] epc;
    logic [7:0] esp;
    logic [7:0] eaddr;
    logic [7:0] edata;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    '{8'h16, 8'h10, 8'h40, 8'h00, 1'b0, 8'h40, 8'hFF, 8'h00, 8'h00},
    '{8'h25, 8'h10, 8'h00, 8'h88, 1'b0, 8'h88, 8'hFF, 8'h00, 8'h00},
    '{8'h17, 8'h20, 8'h50, 8'h00, 1'b1, 8'h50, 8'hFF, 8'h00, 8'h00},
    '{8'h17, 8'h20, 8'h50, 8'h00, 1'b0, 8'h22, 8'hFF, 8'h00, 8'h00},
    '{8'h18, 8'h20, 8'h60, 8'h00, 1'b0, 8'h60, 8'hFF, 8'h00, 8'h00},
    '{8'h18, 8'h30, 8'h60, 8'h00, 1'b1, 8'h32, 8'hFF, 8'h00, 8'h00},
    '{8'h07, 8'h30, 8'h00, 8'hA5, 1'b0, 8'h32, 8'hFE, 8'hFF, 8'hA5},
    '{8'h07, 8'h32, 8'h00, 8'h3C, 1'b0, 8'h34, 8'hFD, 8'hFE, 8'h3C},
    '{8'h20, 8'h34, 8'h70, 8'h00, 1'b0, 8'h70, 8'hFC, 8'hFD, 8'h36},
    '{8'h26, 8'h70, 8'h00, 8'h90, 1'b0, 8'h90, 8'hFB, 8'hFC, 8'h72},
    '{8'h21, 8'h90, 8'h00, 8'h00, 1'b0, 8'h72, 8'hFC, 8'hFC, 8'h72},
    '{8'h21, 8'h74, 8'h00, 8'h00, 1'b0, 8'h36, 8'hFD, 8'hFD, 8'h36},
    '{8'h08, 8'h36, 8'h00, 8'h00, 1'b0, 8'h38, 8'hFE, 8'hFE, 8'h3C},
    '{8'h08, 8'h38, 8'h00, 8'h00, 1'b0, 8'h3A, 8'hFF, 8'hFF, 8'hA5},
    '{8'h08, 8'h3A, 8'h00, 8'h00, 1'b0, 8'h3C, 8'h00, 8'h00, 8'hFF},
    '{8'h07, 8'hFE, 8'h00, 8'h11, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h11},
    '{8'h17, 8'hFF, 8'h00, 8'h00, 1'b0, 8'h01, 8'hFF, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_op, cur_pc, imm_addr, reg_val;
  logic       zero_flag;
  logic       busy, pc_valid, pop_valid, mem_we, mem_re;
  logic [7:0] pc_next, pop_data, sp_value, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] bmem [256];

  int ncmp = 0;
  int nmis = 0;
  int cyc  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stack_flow_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .cur_pc    (cur_pc),
    .imm_addr  (imm_addr),
    .reg_val   (reg_val),
    .zero_flag (zero_flag),
    .busy      (busy),
    .pc_valid  (pc_valid),
    .pc_next   (pc_next),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .sp_value  (sp_value),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // bench memory: each byte starts as the complement of its address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= ~i[7:0];
    end else if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      nmis = nmis + 1;
      ncmp = ncmp + 1;
      $display("FAIL R9 watchdog: actual %0d cycles, expected fewer than 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ncmp = ncmp + 1;
    if (act !== exp) begin
      nmis = nmis + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op, input int idx);
    if (idx >= 14) return "R10";
    case (op)
      8'h16, 8'h25: return "R3";
      8'h17, 8'h18: return "R4";
      8'h07:        return "R5";
      8'h08:        return "R6";
      8'h20, 8'h26: return "R7";
      8'h21:        return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic drive(input logic v, input logic [7:0] op, input logic [7:0] pc,
                       input logic [7:0] imm, input logic [7:0] rv, input logic z);
    req_valid = v;
    req_op    = op;
    cur_pc    = pc;
    imm_addr  = imm;
    reg_val   = rv;
    zero_flag = z;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    string tag;
    bit    stk;
    bit    wr;
    tag = tag_of(v.op, idx);
    stk = (v.op == 8'h07) || (v.op == 8'h08) || (v.op == 8'h20) ||
          (v.op == 8'h21) || (v.op == 8'h26);
    wr  = (v.op == 8'h07) || (v.op == 8'h20) || (v.op == 8'h26);
    @(negedge clk);
    drive(1'b1, v.op, v.pc, v.imm, v.rv, v.z);
    @(negedge clk);
    drive(1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    if (stk) begin
      chk(tag, "busy in access", busy, 1);
      chk(tag, "mem_we", mem_we, wr);
      chk(tag, "mem_re", mem_re, !wr);
      chk(tag, "mem_addr", mem_addr, v.eaddr);
      if (wr) chk(tag, "mem_wdata", mem_wdata, v.edata);
      chk(tag, "pc_valid in access", pc_valid, 0);
      @(negedge clk);
    end
    chk(tag, "pc_valid", pc_valid, 1);
    chk(tag, "pc_next", pc_next, v.epc);
    chk(tag, "pop_valid", pop_valid, (v.op == 8'h08));
    if (v.op == 8'h08) chk(tag, "pop_data", pop_data, v.edata);
    chk(tag, "sp_value", sp_value, v.esp);
    chk(tag, "busy after", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "sp in reset", sp_value, 8'hFF);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "pc_valid in reset", pc_valid, 0);
    chk("R1", "pop_valid in reset", pop_valid, 0);
    chk("R1", "strobes in reset", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sp after release", sp_value, 8'hFF);
    chk("R1", "busy after release", busy, 0);

    for (int i = 0; i < NVEC; i++) run_vec(i, TBL[i]);

    // R9: request held during the busy cycle of a push is dropped
    @(negedge clk);
    drive(1'b1, 8'h07, 8'h40, 8'h00, 8'h77, 1'b0);
    @(negedge clk);
    drive(1'b1, 8'h16, 8'h50, 8'hE0, 8'h00, 1'b0);
    chk("R9", "busy during push", busy, 1);
    @(negedge clk);
    drive(1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R9", "pc_valid after push", pc_valid, 1);
    chk("R9", "pc_next is push result", pc_next, 8'h42);
    chk("R9", "sp after push", sp_value, 8'hFE);
    @(negedge clk);
    chk("R9", "dropped jump gives no pc_valid", pc_valid, 0);
    chk("R9", "no second busy", busy, 0);

    // R2: unrecognised opcodes
    @(negedge clk);
    drive(1'b1, 8'h05, 8'h60, 8'h33, 8'h44, 1'b1);
    @(negedge clk);
    drive(1'b1, 8'h00, 8'h60, 8'h33, 8'h44, 1'b0);
    chk("R2", "pc_valid after 0x05", pc_valid, 0);
    chk("R2", "busy after 0x05", busy, 0);
    chk("R2", "strobes after 0x05", {mem_we, mem_re}, 0);
    @(negedge clk);
    drive(1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R2", "pc_valid after 0x00", pc_valid, 0);
    chk("R2", "busy after 0x00", busy, 0);
    chk("R2", "sp unchanged", sp_value, 8'hFE);
    @(negedge clk);
    chk("R11", "strobes idle", {mem_we, mem_re}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

endmodule